// File: doc/BRIEF.md
# Relative Branch Target and Timing Unit

This unit settles a conditional relative jump for a small processor whose program counter is 16 bits wide and whose jump instruction is two bytes long. The caller supplies the address of the jump instruction, the one-byte signed displacement and an already-evaluated condition bit, all qualified by a request strobe. One clock later the unit returns the address of the next instruction to fetch and the number of clock cycles the jump instruction costs, together with a one-cycle completion pulse.

Displacements are measured from the address that follows the two-byte instruction, which is the fall-through address. A jump that is not taken costs the base of two cycles. A jump that is taken costs one more cycle. It costs one further cycle when the upper byte of the target differs from the upper byte of the fall-through address. All address arithmetic wraps around the 64 KiB space. Decoding which flag a given opcode tests is left to the caller.

Top module: `rb_branch_resolve`

## Requirements
- R1: While `rst` is high on a clock edge, the registered outputs are cleared: `done_o`=0, `next_pc_o`=0x0000, `cycles_o`=0.
- R2: `done_o` is high for exactly the one cycle that follows each cycle in which `req_valid_i` is high, and is low otherwise.
- R3: For a request with `take_i`=0, `next_pc_o` becomes `pc_i`+2 and `cycles_o` becomes 2.
- R4: For a request with `take_i`=1, `next_pc_o` becomes `pc_i`+2+D, where D is `disp_i` read as a two's-complement value in the range -128..+127.
- R5: A taken request whose target has the same upper byte (bits 15:8) as `pc_i`+2 reports `cycles_o`=3.
- R6: A taken request whose target has a different upper byte from `pc_i`+2 reports `cycles_o`=4. Both forward and backward displacements count.
- R7: The fall-through and target sums wrap modulo 65536. For example, 0xFFFE+2 gives 0x0000 and 0x0000+2-16 gives 0xFFF2.
- R8: A taken request with `disp_i`=0xFE returns `next_pc_o`=`pc_i`. It costs 3 cycles, or 4 when `pc_i`+2 lies in the next page up (for example `pc_i`=0x12FE).
- R9: In a cycle without a request, `next_pc_o` and `cycles_o` keep their previous values.
- R10: A jump that is not taken costs 2 cycles even when `pc_i`+2 itself lies in the next page (for example `pc_i`=0x12FF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Request strobe qualifying the three inputs below |
| pc_i | input | 16 | Address of the jump instruction |
| disp_i | input | 8 | Signed displacement byte |
| take_i | input | 1 | Evaluated condition, 1 = jump taken |
| done_o | output | 1 | One-cycle pulse marking fresh results |
| next_pc_o | output | 16 | Address of the next instruction |
| cycles_o | output | 3 | Cycle cost of the jump instruction (2, 3 or 4) |

## Verification
The hardest cases to reach are those where the page test and the instruction length interact. In these cases `pc_i` itself sits at the end of a page, so the fall-through address is already in the next page, and the page comparison has to use `pc_i`+2 rather than `pc_i`. The vector table drives addresses such as 0x12FE and 0x12FF with the self-targeting displacement 0xFE and with jumps not taken. It also drives addresses around 0x0000 and 0xFFFE to force the 16-bit wrap in both directions. Idle cycles are placed between requests so that result holding and the single-cycle completion pulse can be seen at the ports.

// File: rtl/rb_pkg.sv
package rb_pkg;

    // Cost classes of a resolved relative jump
    typedef enum logic [1:0] {
        BR_SKIP = 2'd0,   // condition false, fall through
        BR_NEAR = 2'd1,   // taken, target in the fall-through page
        BR_FAR  = 2'd2    // taken, target in another page
    } br_kind_e;

    localparam int CYC_BASE  = 2;
    localparam int CYC_TAKEN = 1;
    localparam int CYC_PAGE  = 1;

    function automatic int unsigned kind_cycles(br_kind_e kind);
        case (kind)
            BR_NEAR: return CYC_BASE + CYC_TAKEN;
            BR_FAR:  return CYC_BASE + CYC_TAKEN + CYC_PAGE;
            default: return CYC_BASE;
        endcase
    endfunction

endpackage

// File: rtl/rb_target_calc.sv
module rb_target_calc #(
    parameter int PC_W      = 16,
    parameter int DISP_W    = 8,
    parameter int INSTR_LEN = 2
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [PC_W-1:0]   seq_pc_o,
    output logic [PC_W-1:0]   jump_pc_o
);
    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;

    // sign-extend displacement to address width
    assign disp_ext  = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    // both sums are truncated to PC_W, giving modulo-2^PC_W wrap
    assign seq_pc_o  = pc_i + PC_W'(INSTR_LEN);
    assign jump_pc_o = seq_pc_o + disp_ext;
endmodule

// File: rtl/rb_page_cmp.sv
module rb_page_cmp
    import rb_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int PAGE_BITS = 8
) (
    input  logic [PC_W-1:0] seq_pc_i,
    input  logic [PC_W-1:0] jump_pc_i,
    input  logic            take_i,
    output br_kind_e        kind_o
);
    logic page_diff;

    assign page_diff = (seq_pc_i[PC_W-1:PAGE_BITS] != jump_pc_i[PC_W-1:PAGE_BITS]);

    always_comb begin
        if (!take_i)        kind_o = BR_SKIP;
        else if (page_diff) kind_o = BR_FAR;
        else                kind_o = BR_NEAR;
    end
endmodule

// File: rtl/rb_branch_resolve.sv
module rb_branch_resolve
    import rb_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int DISP_W    = 8,
    parameter int PAGE_BITS = 8,
    parameter int INSTR_LEN = 2,
    parameter int CYC_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              take_i,
    output logic              done_o,
    output logic [PC_W-1:0]   next_pc_o,
    output logic [CYC_W-1:0]  cycles_o
);
    logic [PC_W-1:0]  seq_pc;
    logic [PC_W-1:0]  jump_pc;
    br_kind_e         kind;
    logic [PC_W-1:0]  pc_sel;
    logic [CYC_W-1:0] cyc_sel;

    rb_target_calc #(
        .PC_W      (PC_W),
        .DISP_W    (DISP_W),
        .INSTR_LEN (INSTR_LEN)
    ) target_i (
        .pc_i      (pc_i),
        .disp_i    (disp_i),
        .seq_pc_o  (seq_pc),
        .jump_pc_o (jump_pc)
    );

    rb_page_cmp #(
        .PC_W      (PC_W),
        .PAGE_BITS (PAGE_BITS)
    ) page_i (
        .seq_pc_i  (seq_pc),
        .jump_pc_i (jump_pc),
        .take_i    (take_i),
        .kind_o    (kind)
    );

    always_comb begin
        pc_sel  = take_i ? jump_pc : seq_pc;
        cyc_sel = CYC_W'(kind_cycles(kind));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o    <= 1'b0;
            next_pc_o <= '0;
            cycles_o  <= '0;
        end else begin
            done_o <= req_valid_i;
            if (req_valid_i) begin
                next_pc_o <= pc_sel;
                cycles_o  <= cyc_sel;
            end
        end
    end

    // R2
    done_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> done_o);

    // R2
    done_only_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> !done_o);

    // R3
    skip_cost_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !take_i) |=>
            (cycles_o == CYC_W'(2)) && (next_pc_o == $past(pc_i) + PC_W'(INSTR_LEN)));

    // R5
    taken_cost_range_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && take_i) |=> (cycles_o == CYC_W'(3)) || (cycles_o == CYC_W'(4)));

    // R8
    self_loop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && take_i && disp_i == DISP_W'(-INSTR_LEN)) |=> next_pc_o == $past(pc_i));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> $stable(next_pc_o) && $stable(cycles_o));
endmodule

// File: tb/rb_branch_resolve_tb_top.sv
module rb_branch_resolve_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [7:0]  disp_i = '0;
    logic        take_i = 1'b0;
    logic        done_o;
    logic [15:0] next_pc_o;
    logic [2:0]  cycles_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    rb_branch_resolve dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid_i),
        .pc_i        (pc_i),
        .disp_i      (disp_i),
        .take_i      (take_i),
        .done_o      (done_o),
        .next_pc_o   (next_pc_o),
        .cycles_o    (cycles_o)
    );

    // {pc, disp, take, expected next pc, expected cycles, requirement number}
    localparam int NV = 14;
    localparam logic [55:0] VEC [NV] = '{
        {16'h1000, 8'h05, 1'b0, 16'h1002, 3'd2, 4'd0, 8'd3},   // R3
        {16'h1000, 8'h05, 1'b1, 16'h1007, 3'd3, 4'd0, 8'd5},   // R5 forward
        {16'h1000, 8'hF0, 1'b1, 16'h0FF2, 3'd4, 4'd0, 8'd6},   // R6 backward cross
        {16'h10F0, 8'h20, 1'b1, 16'h1112, 3'd4, 4'd0, 8'd6},   // R6 forward cross
        {16'h10F0, 8'h0D, 1'b1, 16'h10FF, 3'd3, 4'd0, 8'd5},   // R5 page edge
        {16'h1234, 8'h80, 1'b1, 16'h11B6, 3'd4, 4'd0, 8'd4},   // R4 -128
        {16'h1234, 8'h7F, 1'b1, 16'h12B5, 3'd3, 4'd0, 8'd4},   // R4 +127
        {16'hFFFE, 8'h10, 1'b1, 16'h0010, 3'd3, 4'd0, 8'd7},   // R7 wrap up
        {16'h0000, 8'hF0, 1'b1, 16'hFFF2, 3'd4, 4'd0, 8'd7},   // R7 wrap down
        {16'h2000, 8'hFE, 1'b1, 16'h2000, 3'd3, 4'd0, 8'd8},   // R8 tight loop
        {16'h12FE, 8'hFE, 1'b1, 16'h12FE, 3'd4, 4'd0, 8'd8},   // R8 loop across page
        {16'h12FF, 8'h80, 1'b0, 16'h1301, 3'd2, 4'd0, 8'd10},  // R10
        {16'hFFFF, 8'h00, 1'b0, 16'h0001, 3'd2, 4'd0, 8'd7},   // R7 fall-through wrap
        {16'h4567, 8'h00, 1'b1, 16'h4569, 3'd3, 4'd0, 8'd4}    // R4 zero displacement
    };

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic check_out(input int rq, input logic [15:0] epc, input logic [2:0] ecyc,
                             input logic edone);
        check(next_pc_o == epc, rq, "next_pc", 32'(next_pc_o), 32'(epc));
        check(cycles_o == ecyc, rq, "cycles", 32'(cycles_o), 32'(ecyc));
        check(done_o == edone, rq, "done", 32'(done_o), 32'(edone));
    endtask

    task automatic issue(input logic [15:0] pc, input logic [7:0] d, input logic t);
        @(negedge clk);
        req_valid_i = 1'b1; pc_i = pc; disp_i = d; take_i = t;
        @(negedge clk);
        req_valid_i = 1'b0; pc_i = 16'hDEAD; disp_i = 8'h55; take_i = ~t;
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check_out(1, 16'h0000, 3'd0, 1'b0);
        rst = 1'b0;

        // table walk, each request followed by an idle cycle
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][55:40], VEC[i][39:32], VEC[i][31]);
            check_out(int'(VEC[i][7:0]), VEC[i][30:15], VEC[i][14:12], 1'b1);
            @(negedge clk);
            // R9 hold and R2 single pulse
            check_out(9, VEC[i][30:15], VEC[i][14:12], 1'b0);
        end

        // R2 back-to-back requests
        @(negedge clk);
        req_valid_i = 1'b1; pc_i = 16'h3000; disp_i = 8'h10; take_i = 1'b1;
        @(negedge clk);
        check_out(2, 16'h3012, 3'd3, 1'b1);
        pc_i = 16'h30FF; disp_i = 8'h00; take_i = 1'b0;
        @(negedge clk);
        req_valid_i = 1'b0;
        check_out(2, 16'h3101, 3'd2, 1'b1);
        @(negedge clk);
        check_out(2, 16'h3101, 3'd2, 1'b0);

        // R1 reset after activity, with a request present
        req_valid_i = 1'b1; pc_i = 16'h5000; take_i = 1'b1; rst = 1'b1;
        @(negedge clk);
        check_out(1, 16'h0000, 3'd0, 1'b0);
        req_valid_i = 1'b0; rst = 1'b0;
        @(negedge clk);
        check_out(1, 16'h0000, 3'd0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule